// File: doc/BRIEF.md
# SPI-Mode Card Data Packet Receiver

This block reads one data packet from a memory card that is run in SPI mode. It sits above a byte-exchange SPI master. For each byte slot it raises a request with a fill byte of 0xFF and takes back the byte the card returned. After a start pulse it polls until the card stops answering 0xFF. If the first other byte is the start token 0xFE, it reads the payload, then two checksum bytes that it does not keep, and reports completion. Any other first byte, or a timeout measured in ticks of a slow timebase, ends the packet with an error.

The payload length is a count of two-byte pairs, so a sector read (count 0, taken as 256 pairs) and a 16-byte card register read (count 8) use the same path. Payload bytes leave on a valid/ready stream. Back-pressure rules: `out_valid` stays high, and `out_data` stays unchanged, until a cycle with `out_ready` high. While a byte is held, no further payload exchange is requested. Completion is held back until the last payload byte has been accepted. The checksum bytes may be exchanged while the last payload byte is still held. `TIMEOUT_TICKS` sets the timeout: the default of 10 gives 100 ms with a 10 ms tick.

Top module: `card_block_rx`

## Requirements
- R1: After reset, `xfer_req`, `out_valid`, `done` and `error` are all low, and they stay low until `start` is pulsed.
- R2: Every exchange requested (`xfer_req` high) carries `xfer_tx` = 0xFF. An exchange completes in the cycle where `xfer_done` is high while `xfer_req` is high.
- R3: A received 0xFF during the token search keeps the block polling. A first non-0xFF byte equal to 0xFE begins the payload.
- R4: A first non-0xFF byte other than 0xFE ends the packet with `done` and `error` both high for one cycle. No `out_valid` pulse follows, and no further exchange is requested.
- R5: The timer is reloaded with `TIMEOUT_TICKS` at start and counts down on each `tick` pulse. A 0xFF received after it reaches zero ends the packet with an error. A byte that completes after expiry is still judged on its value, so a token received then is accepted.
- R6: The payload is `2*pair_count` bytes, with `pair_count` = 0 meaning 512 bytes. The bytes are delivered on `out_data` in the order they were received.
- R7: After the payload, exactly two more bytes are exchanged and discarded. After `done`, no further exchange is requested.
- R8: `out_valid` and `out_data` hold steady until accepted with `out_ready`.
- R9: `done` is a one-cycle pulse, and `error` is never high without `done`. On success, `done` comes only after the last payload byte was accepted.
- R10: A `start` pulse that arrives while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (ignored when busy) |
| pair_count | input | 8 | Payload length in byte pairs, 0 = 256 |
| tick | input | 1 | Timebase pulse for the timeout |
| xfer_req | output | 1 | Byte exchange request to the SPI master |
| xfer_tx | output | 8 | Byte to send (always 0xFF) |
| xfer_done | input | 1 | Exchange complete, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received from the card |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Sink accepts payload byte |
| done | output | 1 | Packet finished (pulse) |
| error | output | 1 | Packet failed (with `done`) |

## Verification
Two events can land in the same byte slot: the timeout expiring and the start token arriving. The bench provokes this by holding one exchange open for longer than the whole timeout while ticks run, then completing it with 0xFE. The packet is judged correct only if it completes without error and delivers the full payload. The opposite case, where only 0xFF arrives while ticks run, must end in an error with no data. A second overlap, where a checksum exchange runs while the last payload byte is held by random back-pressure, is judged by the hold checks on the stream and by a late `done`.

// File: rtl/card_rx_pkg.sv
`timescale 1ns/1ps
package card_rx_pkg;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] START_TOK  = 8'hFE;
  localparam int         CRC_LEN    = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HUNT,
    S_PAY,
    S_CRC,
    S_FIN,
    S_FAIL
  } rx_state_t;
endpackage

// File: rtl/tmo_timer.sv
`timescale 1ns/1ps
module tmo_timer #(
  parameter int TICKS = 10,
  localparam int TW = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= TW'(TICKS);
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5
  no_count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/pkt_counter.sv
`timescale 1ns/1ps
module pkt_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));
endmodule

// File: rtl/out_stage.sv
`timescale 1ns/1ps
module out_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/card_block_rx.sv
`timescale 1ns/1ps
module card_block_rx
  import card_rx_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TIMEOUT_TICKS = 10,
  localparam int BYTE_W       = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pair_count,
  input  logic             tick,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_done,
  input  logic [7:0]       xfer_rx,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             error
);
  rx_state_t st, nxt;

  logic              tmr_load, tmr_expired;
  logic              cnt_load, cnt_dec, cnt_last;
  logic [BYTE_W-1:0] cnt_val, pay_bytes;
  logic              out_load, take;

  // zero pairs stands for the full 2^CNT_W pairs
  assign pay_bytes = {(pair_count == '0), pair_count, 1'b0};

  assign xfer_req = (st == S_HUNT) || (st == S_CRC) || (st == S_PAY && !out_valid);
  assign xfer_tx  = FILL_BYTE;
  assign take     = xfer_req && xfer_done;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    out_load = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        nxt      = S_HUNT;
        tmr_load = 1'b1;
        cnt_load = 1'b1;
        cnt_val  = pay_bytes;
      end
      S_HUNT: if (take) begin
        // the received byte is judged first; expiry only ends a busy poll
        if (xfer_rx == START_TOK)      nxt = S_PAY;
        else if (xfer_rx != FILL_BYTE) nxt = S_FAIL;
        else if (tmr_expired)          nxt = S_FAIL;
      end
      S_PAY: if (take) begin
        out_load = 1'b1;
        if (cnt_last) begin
          cnt_load = 1'b1;
          cnt_val  = BYTE_W'(CRC_LEN);
          nxt      = S_CRC;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      S_CRC: if (take) begin
        if (cnt_last) nxt = S_FIN;
        else          cnt_dec = 1'b1;
      end
      S_FIN:  if (!out_valid) nxt = S_IDLE;
      S_FAIL: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  assign done  = (st == S_FIN && !out_valid) || (st == S_FAIL);
  assign error = (st == S_FAIL);

  tmo_timer #(.TICKS(TIMEOUT_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .tick(tick), .expired(tmr_expired)
  );

  pkt_counter #(.W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  out_stage #(.DW(8)) u_out (
    .clk(clk), .rst_n(rst_n), .load(out_load), .din(xfer_rx),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data)
  );

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
  // R6
  data_from_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(xfer_done));
  // R4
  no_data_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !out_valid);
endmodule

// File: tb/sim_card_block_rx.sv
`timescale 1ns/1ps
module sim_card_block_rx;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0;
  logic       xfer_done = 1'b0, out_ready = 1'b0;
  logic [7:0] pair_count = 8'd0, xfer_rx = 8'hFF;
  logic       xfer_req, out_valid, done, error;
  logic [7:0] xfer_tx, out_data;

  card_block_rx u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_count(pair_count), .tick(tick),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .error(error)
  );

  always #2.5 clk = ~clk;

  logic [7:0] card [0:1023];
  logic [7:0] rx_buf [0:1023];
  int card_len = 0, card_idx = 0, xcnt = 0, force_lat = 0, rx_cnt = 0;
  int tick_gap = 0, tick_ctr = 0, nchk = 0, nfail = 0;
  bit done_seen = 0, err_seen = 0, prev_done = 0, bp_random = 0, hold_pend = 0;
  logic [7:0] hold_data = 8'd0;

  function automatic int exp_bytes(int pc);
    return (pc == 0) ? 512 : 2 * pc;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // byte-exchange SPI master model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_req) begin
        int lat;
        chk(xfer_tx == 8'hFF, "R2", "fill byte", xfer_tx, 255);
        lat = (force_lat > 0) ? force_lat : $urandom_range(0, 3);
        force_lat = 0;
        repeat (lat) @(negedge clk);
        xfer_rx = (card_idx < card_len) ? card[card_idx] : 8'hFF;
        card_idx++;
        xcnt++;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  // timebase
  initial begin
    forever begin
      @(negedge clk);
      if (tick_gap > 0) begin
        tick_ctr++;
        tick = (tick_ctr % tick_gap == 0);
      end else begin
        tick = 1'b0;
      end
    end
  end

  // sink and status monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid && out_data == hold_data, "R8", "held byte", out_data, hold_data);
      out_ready = bp_random ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (rx_cnt < 1024) rx_buf[rx_cnt] = out_data;
        rx_cnt++;
        hold_pend = 0;
      end else if (out_valid) begin
        hold_pend = 1;
        hold_data = out_data;
      end else begin
        hold_pend = 0;
      end
      if (error && !done) chk(0, "R9", "error without done", 1, 0);
      if (done) begin
        if (prev_done) chk(0, "R9", "done longer than one cycle", 2, 1);
        done_seen = 1;
        err_seen  = error;
      end
      prev_done = done;
    end
  end

  task automatic run(int pc, int busy, logic [7:0] tok, int lat_first,
                     bit exp_err, bit poke, string rq);
    int n = exp_bytes(pc);
    int base = busy + 1;
    int t = 0, bad = 0, x0;
    for (int i = 0; i < busy; i++) card[i] = 8'hFF;
    card[busy] = tok;
    for (int i = 0; i < n + 2; i++) card[base + i] = 8'($urandom);
    card_len = (tok == 8'hFE) ? base + n + 2 : base;
    card_idx = 0; xcnt = 0; rx_cnt = 0; done_seen = 0; err_seen = 0;
    force_lat = lat_first;
    @(negedge clk);
    pair_count = 8'(pc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (15) @(negedge clk);
      pair_count = 8'(pc + 5); start = 1'b1;  // R10: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done_seen && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(done_seen, rq, "done reached", done_seen, 1);
    chk(err_seen == exp_err, rq, "error flag", err_seen, exp_err);
    if (exp_err) begin
      chk(rx_cnt == 0, "R4", "bytes after failed token", rx_cnt, 0);
    end else begin
      chk(rx_cnt == n, poke ? "R10" : "R6", "payload length", rx_cnt, n);
      for (int i = 0; i < n && i < rx_cnt; i++)
        if (rx_buf[i] != card[base + i]) bad++;
      chk(bad == 0, "R6", "payload mismatches", bad, 0);
      chk(xcnt == base + n + 2, "R7", "exchange count with crc", xcnt, base + n + 2);
      chk(card_idx == card_len, "R3", "bytes polled", card_idx, card_len);
    end
    x0 = xcnt;
    repeat (12) @(negedge clk);
    chk(xcnt == x0 && !xfer_req, "R7", "no exchange after done", xcnt, x0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk(!xfer_req && !out_valid && !done && !error, "R1", "idle outputs",
        {xfer_req, out_valid, done, error}, 0);

    bp_random = 0;
    run(1, 0, 8'hFE, 0, 0, 0, "R3");
    run(8, 3, 8'hFE, 0, 0, 0, "R3");
    bp_random = 1;
    run(0, 5, 8'hFE, 0, 0, 0, "R6");
    for (int k = 0; k < 6; k++)
      run($urandom_range(1, 255), $urandom_range(0, 12), 8'hFE, 0, 0, 0, "R6");
    run(255, 1, 8'hFE, 0, 0, 0, "R8");

    // R4 bad tokens
    run(4, 2, 8'h00, 0, 1, 0, "R4");
    run(4, 0, 8'hFC, 0, 1, 0, "R4");

    // R5 timeout with card busy forever
    tick_gap = 4;
    run(4, 10, 8'hFF, 0, 1, 0, "R5");
    // R5 token lands in the slot where the timer has run out
    run(2, 0, 8'hFE, 200, 0, 0, "R5");
    tick_gap = 0;

    // R10 start while busy
    bp_random = 0;
    run(3, 30, 8'hFE, 0, 0, 1, "R10");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule